// File: doc/BRIEF.md
# Buffered Capture/Compare Timer Register Bank

This block holds the counters and the general and buffer registers of a two-channel up-counting timer. Each channel has a counter, two general registers (A and B) and two buffer registers (C and D). C shadows A and D shadows B, and each of these four pairings per block half is switched on by its own enable bit. The mode input decides which way data moves between a buffer and its general register, and which event moves it.

In capture mode a synchronized edge on a channel's capture pin stores the counter in the general register. When buffering is on, the value that was there before moves into the buffer on the same clock edge. In the three compare-style modes the buffer is the source instead. In plain compare/PWM mode each general register is reloaded from its buffer on its own compare match. In reset-synchronous PWM mode, a match of channel 0's counter against A0 restarts counter 0 and reloads B0, A1 and B1; counter 1 then tracks counter 0. In the simplified complementary mode, either that same A0 match or a counter-1 underflow strobe reloads all four general registers at once.

Software reaches every register through one addressed write port and reads all of them back on flat read-back buses. Combinational match flags report, in the compare-style modes, when a counter equals its A or B register.

Top module: `bufcc_timer`

## Requirements
- R1: While rst_n is low, every counter, general register and buffer register reads back as zero.
- R2: Outside reset-synchronous mode each counter adds one per clock and wraps from 0xFFFF to 0. A write with wr_reg = 4 loads the counter of channel wr_ch instead.
- R3: A write with wr_en high stores wr_data in channel wr_ch at the next edge. The register is chosen by wr_reg: 0 = A, 1 = B, 2 = C, 3 = D, 4 = counter.
- R4: In capture mode (mode = 2'b00), a pin's 3-bit I/O code picks the capture edge: 3'b100 captures on a falling edge and 3'b101 on a rising edge. Any other code captures nothing. If a pin changes before clock edge k, then at edge k+2 A (or B) takes the value the counter held just before that edge. An edge of the other polarity leaves the register unchanged.
- R5: On a capture with the buffer enabled (buf_en_c for A, buf_en_d for B), the buffer takes the general register's old value on the same edge. With the buffer disabled, the buffer keeps its value.
- R6: In compare mode (mode = 2'b01), match_a (match_b) of a channel is high while its counter equals its A (B). At the next edge A takes C (B takes D) if that buffer is enabled. If the buffer is disabled, A (B) is unchanged.
- R7: In reset-synchronous mode (mode = 2'b10), an A0 match clears counter 0 at the next edge. On the same edge B0 takes D0, A1 takes C1 and B1 takes D1, each only if enabled. A0 is not reloaded, and counter 1 always equals counter 0.
- R8: In complementary mode (mode = 2'b11), an A0 match or a high unf1_stb loads A0, B0, A1 and B1 from their enabled buffers at the next edge. Without either event and without writes, no general register changes.
- R9: If a CPU write to a buffer lands on the edge where that buffer is the source of a transfer, the general register gets the old buffer value and the buffer gets the written value. A hardware load of a register overrides a CPU write to that register on the same edge.
- R10: In capture mode the match flags stay low and no compare-driven transfer takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 00 capture, 01 compare/PWM, 10 reset-synchronous PWM, 11 complementary |
| cap_a_pin | input | NCH | Capture pins for the A registers |
| cap_b_pin | input | NCH | Capture pins for the B registers |
| io_cfg_a | input | 3*NCH | Edge code per A capture pin |
| io_cfg_b | input | 3*NCH | Edge code per B capture pin |
| buf_en_c | input | NCH | Enable C as the buffer of A, per channel |
| buf_en_d | input | NCH | Enable D as the buffer of B, per channel |
| unf1_stb | input | 1 | Counter-1 underflow strobe |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | CHW | Channel of the write |
| wr_reg | input | 3 | Register selector of the write |
| wr_data | input | CW | Write data |
| rd_cnt | output | NCH*CW | Counters, channel 0 in the low bits |
| rd_a | output | NCH*CW | General registers A |
| rd_b | output | NCH*CW | General registers B |
| rd_c | output | NCH*CW | Buffer registers C |
| rd_d | output | NCH*CW | Buffer registers D |
| match_a | output | NCH | Counter equals A (compare-style modes) |
| match_b | output | NCH | Counter equals B (compare-style modes) |

## Verification
Compare-mode reloads are driven with random general values, buffer values, channels and enable bits. This separates a working reload from one that ignores its enable or acts on the wrong channel. Directed capture runs use both edge codes and both edge polarities, with and without the buffer. Mismatched polarities must leave A alone, and with the buffer disabled C must keep its value. The two PWM modes are each driven up to the A0 match, and complementary mode also gets the underflow strobe. These runs show which registers each event reloads and that counter 0 restarts. A buffer write placed exactly on the reload edge shows whether the transfer reads the old buffer value.

// File: rtl/bufcc_pkg.sv
package bufcc_pkg;
    localparam int NCH = 2;
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

    typedef enum logic [1:0] {
        MD_CAPTURE = 2'b00,
        MD_COMPARE = 2'b01,
        MD_RSYNC   = 2'b10,
        MD_COMPL   = 2'b11
    } tmode_e;

    localparam logic [2:0] SEL_A   = 3'd0;
    localparam logic [2:0] SEL_B   = 3'd1;
    localparam logic [2:0] SEL_C   = 3'd2;
    localparam logic [2:0] SEL_D   = 3'd3;
    localparam logic [2:0] SEL_CNT = 3'd4;

    localparam logic [2:0] EDGE_FALL = 3'b100;
    localparam logic [2:0] EDGE_RISE = 3'b101;
endpackage

// File: rtl/bufcc_cap_front.sv
module bufcc_cap_front
    import bufcc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_in,
    input  logic [2:0] cfg,
    input  logic       enable,
    output logic       cap_evt
);
    localparam int SW = STAGES + 1;

    logic [SW-1:0] sh_d, sh_q;
    logic          newest, oldest;

    always_comb begin
        sh_d    = {sh_q[SW-2:0], pin_in};
        newest  = sh_q[STAGES-1];
        oldest  = sh_q[STAGES];
        cap_evt = 1'b0;
        if (enable) begin
            if (cfg == EDGE_FALL) cap_evt = oldest && !newest;
            else if (cfg == EDGE_RISE) cap_evt = !oldest && newest;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end
endmodule

// File: rtl/bufcc_xfer_ctl.sv
module bufcc_xfer_ctl
    import bufcc_pkg::*;
(
    input  tmode_e           md,
    input  logic [NCH-1:0]   hit_a,
    input  logic [NCH-1:0]   hit_b,
    input  logic             unf1_stb,
    input  logic [NCH-1:0]   en_c,
    input  logic [NCH-1:0]   en_d,
    output logic [NCH-1:0]   ld_a,
    output logic [NCH-1:0]   ld_b,
    output logic             clr_cnt0
);
    logic evt;

    always_comb begin
        ld_a     = '0;
        ld_b     = '0;
        clr_cnt0 = 1'b0;
        evt      = 1'b0;
        case (md)
            MD_COMPARE: begin
                ld_a = hit_a & en_c;
                ld_b = hit_b & en_d;
            end
            MD_RSYNC: begin
                evt      = hit_a[0];
                clr_cnt0 = evt;
                ld_b[0]  = evt && en_d[0];
                ld_a[1]  = evt && en_c[1];
                ld_b[1]  = evt && en_d[1];
            end
            MD_COMPL: begin
                evt  = hit_a[0] || unf1_stb;
                ld_a = {NCH{evt}} & en_c;
                ld_b = {NCH{evt}} & en_d;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bufcc_timer.sv
module bufcc_timer
    import bufcc_pkg::*;
#(
    parameter int CW = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic [NCH-1:0]    cap_a_pin,
    input  logic [NCH-1:0]    cap_b_pin,
    input  logic [3*NCH-1:0]  io_cfg_a,
    input  logic [3*NCH-1:0]  io_cfg_b,
    input  logic [NCH-1:0]    buf_en_c,
    input  logic [NCH-1:0]    buf_en_d,
    input  logic              unf1_stb,
    input  logic              wr_en,
    input  logic [CHW-1:0]    wr_ch,
    input  logic [2:0]        wr_reg,
    input  logic [CW-1:0]     wr_data,
    output logic [NCH*CW-1:0] rd_cnt,
    output logic [NCH*CW-1:0] rd_a,
    output logic [NCH*CW-1:0] rd_b,
    output logic [NCH*CW-1:0] rd_c,
    output logic [NCH*CW-1:0] rd_d,
    output logic [NCH-1:0]    match_a,
    output logic [NCH-1:0]    match_b
);
    typedef struct packed {
        logic [NCH-1:0][CW-1:0] cnt;
        logic [NCH-1:0][CW-1:0] ga;
        logic [NCH-1:0][CW-1:0] gb;
        logic [NCH-1:0][CW-1:0] bc;
        logic [NCH-1:0][CW-1:0] bd;
    } bank_t;

    bank_t          st_d, st_q;
    tmode_e         md;
    logic           cap_mode;
    logic [NCH-1:0] cap_a, cap_b;
    logic [NCH-1:0] hit_a, hit_b;
    logic [NCH-1:0] ld_a, ld_b;
    logic           clr_cnt0;
    logic           wr_cnt0;

    assign md       = tmode_e'(mode);
    assign cap_mode = (md == MD_CAPTURE);

    for (genvar g = 0; g < NCH; g++) begin : g_front
        bufcc_cap_front #(.STAGES(SYNC_STAGES)) u_front_a (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_in (cap_a_pin[g]),
            .cfg    (io_cfg_a[g*3 +: 3]),
            .enable (cap_mode),
            .cap_evt(cap_a[g])
        );
        bufcc_cap_front #(.STAGES(SYNC_STAGES)) u_front_b (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_in (cap_b_pin[g]),
            .cfg    (io_cfg_b[g*3 +: 3]),
            .enable (cap_mode),
            .cap_evt(cap_b[g])
        );
    end

    always_comb begin
        for (int ch = 0; ch < NCH; ch++) begin
            hit_a[ch] = (st_q.cnt[ch] == st_q.ga[ch]);
            hit_b[ch] = (st_q.cnt[ch] == st_q.gb[ch]);
        end
        match_a = cap_mode ? '0 : hit_a;
        match_b = cap_mode ? '0 : hit_b;
    end

    bufcc_xfer_ctl u_xfer (
        .md      (md),
        .hit_a   (hit_a),
        .hit_b   (hit_b),
        .unf1_stb(unf1_stb),
        .en_c    (buf_en_c),
        .en_d    (buf_en_d),
        .ld_a    (ld_a),
        .ld_b    (ld_b),
        .clr_cnt0(clr_cnt0)
    );

    assign wr_cnt0 = wr_en && (wr_ch == CHW'(0)) && (wr_reg == SEL_CNT);

    always_comb begin
        st_d = st_q;
        for (int ch = 0; ch < NCH; ch++) begin
            st_d.cnt[ch] = st_q.cnt[ch] + 1'b1;
            // software access first, hardware loads override below
            if (wr_en && (int'(wr_ch) == ch)) begin
                case (wr_reg)
                    SEL_A:   st_d.ga[ch]  = wr_data;
                    SEL_B:   st_d.gb[ch]  = wr_data;
                    SEL_C:   st_d.bc[ch]  = wr_data;
                    SEL_D:   st_d.bd[ch]  = wr_data;
                    SEL_CNT: st_d.cnt[ch] = wr_data;
                    default: ;
                endcase
            end
            if (cap_a[ch]) begin
                st_d.ga[ch] = st_q.cnt[ch];
                if (buf_en_c[ch]) st_d.bc[ch] = st_q.ga[ch];
            end
            if (cap_b[ch]) begin
                st_d.gb[ch] = st_q.cnt[ch];
                if (buf_en_d[ch]) st_d.bd[ch] = st_q.gb[ch];
            end
            if (ld_a[ch]) st_d.ga[ch] = st_q.bc[ch];
            if (ld_b[ch]) st_d.gb[ch] = st_q.bd[ch];
        end
        if (md == MD_RSYNC) begin
            if (clr_cnt0 && !wr_cnt0) st_d.cnt[0] = '0;
            st_d.cnt[1] = st_d.cnt[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_cnt = st_q.cnt;
    assign rd_a   = st_q.ga;
    assign rd_b   = st_q.gb;
    assign rd_c   = st_q.bc;
    assign rd_d   = st_q.bd;
endmodule

// File: rtl/bufcc_timer_chk.sv
module bufcc_timer_chk
    import bufcc_pkg::*;
#(
    parameter int CW = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode,
    input logic              unf1_stb,
    input logic [NCH-1:0]    buf_en_c,
    input logic              wr_en,
    input logic [CHW-1:0]    wr_ch,
    input logic [2:0]        wr_reg,
    input logic [NCH*CW-1:0] rd_cnt,
    input logic [NCH*CW-1:0] rd_a,
    input logic [NCH*CW-1:0] rd_b,
    input logic [NCH*CW-1:0] rd_c,
    input logic [NCH-1:0]    match_a
);
    logic wr_cnt0, wr_a0;
    assign wr_cnt0 = wr_en && (wr_ch == CHW'(0)) && (wr_reg == SEL_CNT);
    assign wr_a0   = wr_en && (wr_ch == CHW'(0)) && (wr_reg == SEL_A);

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_COMPARE && !wr_cnt0) |=> rd_cnt[CW-1:0] == CW'($past(rd_cnt[CW-1:0]) + 1'b1));

    // R6
    cmp_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_COMPARE && match_a[0] && buf_en_c[0] && !wr_a0) |=> rd_a[CW-1:0] == $past(rd_c[CW-1:0]));

    // R7
    rsync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_RSYNC && match_a[0] && !wr_cnt0) |=> rd_cnt[CW-1:0] == '0);

    // R7
    rsync_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_RSYNC) |=> rd_cnt[2*CW-1:CW] == rd_cnt[CW-1:0]);

    // R8
    compl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_COMPL && !match_a[0] && !unf1_stb && !wr_en) |=> (rd_a == $past(rd_a) && rd_b == $past(rd_b)));
endmodule

bind bufcc_timer bufcc_timer_chk #(.CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .unf1_stb(unf1_stb),
    .buf_en_c(buf_en_c),
    .wr_en   (wr_en),
    .wr_ch   (wr_ch),
    .wr_reg  (wr_reg),
    .rd_cnt  (rd_cnt),
    .rd_a    (rd_a),
    .rd_b    (rd_b),
    .rd_c    (rd_c),
    .match_a (match_a)
);

// File: tb/bufcc_timer_test.sv
module bufcc_timer_test;
    import bufcc_pkg::*;
    localparam int CW = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        mode = 2'b01;
    logic [NCH-1:0]    cap_a_pin = '1, cap_b_pin = '1;
    logic [3*NCH-1:0]  io_cfg_a = '0, io_cfg_b = '0;
    logic [NCH-1:0]    buf_en_c = '0, buf_en_d = '0;
    logic              unf1_stb = 1'b0;
    logic              wr_en = 1'b0;
    logic [CHW-1:0]    wr_ch = '0;
    logic [2:0]        wr_reg = '0;
    logic [CW-1:0]     wr_data = '0;
    logic [NCH*CW-1:0] rd_cnt, rd_a, rd_b, rd_c, rd_d;
    logic [NCH-1:0]    match_a, match_b;

    int checks = 0, failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    bufcc_timer #(.CW(CW)) uut (.*);

    function automatic logic [CW-1:0] sl(logic [NCH*CW-1:0] v, int ch);
        return v[ch*CW +: CW];
    endfunction
    function automatic logic [CW-1:0] exp_reload(logic [CW-1:0] gen, logic [CW-1:0] bufv, bit en);
        return en ? bufv : gen;
    endfunction
    function automatic logic [CW-1:0] exp_capture(logic [CW-1:0] cnt_seen);
        return cnt_seen + 16'd2;
    endfunction

    task automatic check(string req, logic [CW-1:0] act, logic [CW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a negedge; write lands at the next posedge, returns at the following negedge
    task automatic wr(int ch, logic [2:0] sel, logic [CW-1:0] data);
        wr_en = 1'b1; wr_ch = CHW'(ch); wr_reg = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [CW-1:0] v, ra, rc, olda;
        int ch;
        bit en;
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 cnt", rd_cnt[CW-1:0], '0);
        check("R1 a1", sl(rd_a, 1), '0);
        check("R1 d1", sl(rd_d, 1), '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 counting, wrap and load
        v = sl(rd_cnt, 0);
        @(negedge clk);
        check("R2 step", sl(rd_cnt, 0), v + 16'd1);
        wr(1, SEL_CNT, 16'hFFFF);
        check("R2 load", sl(rd_cnt, 1), 16'hFFFF);
        @(negedge clk);
        check("R2 wrap", sl(rd_cnt, 1), 16'h0000);

        // R3 direct writes
        wr(1, SEL_B, 16'h0B0B);
        wr(1, SEL_D, 16'h0D0D);
        check("R3 b1", sl(rd_b, 1), 16'h0B0B);
        check("R3 d1", sl(rd_d, 1), 16'h0D0D);

        // R4/R5 capture
        mode = 2'b00;
        io_cfg_a[2:0] = EDGE_FALL;
        buf_en_c[0] = 1'b1;
        wr(0, SEL_A, 16'h1234);
        repeat (3) @(negedge clk);
        v = sl(rd_cnt, 0);
        cap_a_pin[0] = 1'b0;
        repeat (3) @(negedge clk);
        check("R4 fall capture", sl(rd_a, 0), exp_capture(v));
        check("R5 shift to C", sl(rd_c, 0), 16'h1234);
        olda = sl(rd_a, 0);
        cap_a_pin[0] = 1'b1;
        repeat (4) @(negedge clk);
        check("R4 rise ignored under 100", sl(rd_a, 0), olda);
        io_cfg_a[2:0] = EDGE_RISE;
        buf_en_c[0] = 1'b0;
        cap_a_pin[0] = 1'b0;
        repeat (4) @(negedge clk);
        check("R4 fall ignored under 101", sl(rd_a, 0), olda);
        v = sl(rd_cnt, 0);
        cap_a_pin[0] = 1'b1;
        repeat (3) @(negedge clk);
        check("R4 rise capture", sl(rd_a, 0), exp_capture(v));
        check("R5 buffer off keeps C", sl(rd_c, 0), 16'h1234);
        io_cfg_a[2:0] = 3'b000;
        olda = sl(rd_a, 0);
        cap_a_pin[0] = 1'b0;
        repeat (4) @(negedge clk);
        check("R4 code 000 no capture", sl(rd_a, 0), olda);

        // R10 no compare action in capture mode
        buf_en_c[0] = 1'b1;
        wr(0, SEL_C, 16'h5555);
        wr(0, SEL_A, 16'd50);
        wr(0, SEL_CNT, 16'd47);
        repeat (3) @(negedge clk);
        check("R10 match low", 16'(match_a[0]), 16'd0);
        @(negedge clk);
        check("R10 A kept", sl(rd_a, 0), 16'd50);

        // R6 compare reloads, random
        mode = 2'b01;
        for (int it = 0; it < 16; it++) begin
            buf_en_c = '0;
            ch = int'($urandom % 2);
            ra = 16'($urandom % 65000) + 16'd16;
            rc = 16'($urandom);
            en = 1'($urandom % 2);
            wr(ch, SEL_A, ra);
            wr(ch, SEL_C, rc);
            buf_en_c[ch] = en;
            wr(ch, SEL_CNT, ra - 16'd3);
            repeat (3) @(negedge clk);
            check("R6 match flag", 16'(match_a[ch]), 16'd1);
            @(negedge clk);
            check("R6 reload", sl(rd_a, ch), exp_reload(ra, rc, en));
        end

        // R9 buffer write on the reload edge
        buf_en_c = '0;
        wr(0, SEL_A, 16'd300);
        wr(0, SEL_C, 16'hC0DE);
        buf_en_c[0] = 1'b1;
        wr(0, SEL_CNT, 16'd297);
        repeat (3) @(negedge clk);
        wr(0, SEL_C, 16'hBEEF);
        check("R9 A took old buffer", sl(rd_a, 0), 16'hC0DE);
        check("R9 buffer took write", sl(rd_c, 0), 16'hBEEF);

        // R7 reset-synchronous PWM
        mode = 2'b10;
        buf_en_c = '0; buf_en_d = '0;
        wr(0, SEL_A, 16'd10);
        wr(0, SEL_C, 16'hAAA0);
        wr(0, SEL_D, 16'hDDD0);
        wr(1, SEL_C, 16'hAAA1);
        wr(1, SEL_D, 16'hDDD1);
        wr(0, SEL_CNT, 16'd5);
        buf_en_c = '1; buf_en_d = '1;
        repeat (5) @(negedge clk);
        check("R7 match at A0", 16'(match_a[0]), 16'd1);
        check("R7 cnt1 follows", sl(rd_cnt, 1), 16'd10);
        @(negedge clk);
        check("R7 cnt0 cleared", sl(rd_cnt, 0), 16'd0);
        check("R7 B0", sl(rd_b, 0), 16'hDDD0);
        check("R7 A1", sl(rd_a, 1), 16'hAAA1);
        check("R7 B1", sl(rd_b, 1), 16'hDDD1);
        check("R7 A0 not reloaded", sl(rd_a, 0), 16'd10);

        // R8 complementary mode
        mode = 2'b11;
        buf_en_c = '0; buf_en_d = '0;
        wr(0, SEL_A, 16'h9000);
        wr(0, SEL_CNT, 16'h0100);
        wr(0, SEL_C, 16'h00A0);
        wr(0, SEL_D, 16'h00B0);
        wr(1, SEL_C, 16'h00A1);
        wr(1, SEL_D, 16'h00B1);
        buf_en_c = '1; buf_en_d = '1;
        repeat (3) @(negedge clk);
        check("R8 no event hold", sl(rd_a, 1), 16'hAAA1);
        unf1_stb = 1'b1;
        @(negedge clk);
        unf1_stb = 1'b0;
        check("R8 unf A0", sl(rd_a, 0), 16'h00A0);
        check("R8 unf B0", sl(rd_b, 0), 16'h00B0);
        check("R8 unf A1", sl(rd_a, 1), 16'h00A1);
        check("R8 unf B1", sl(rd_b, 1), 16'h00B1);
        buf_en_c = '0; buf_en_d = '0;
        wr(0, SEL_C, 16'h0077);
        wr(1, SEL_C, 16'h0066);
        buf_en_c = '1;
        wr(0, SEL_CNT, 16'h009D);
        repeat (3) @(negedge clk);
        check("R8 A0 match flag", 16'(match_a[0]), 16'd1);
        @(negedge clk);
        check("R8 match A0", sl(rd_a, 0), 16'h0077);
        check("R8 match A1", sl(rd_a, 1), 16'h0066);

        done = 1;
        finish_run();
    end
endmodule